// File: doc/BRIEF.md
# Serial Audio Path Control Register

This block takes 8-bit control words from a three-wire serial bus (data, bit clock and an active-high frame enable) and turns them into the digital controls for an audio output stage. The output stage has one speaker path and a two-channel headset path. All three bus lines are treated as asynchronous. Each line passes through a two-flop synchronizer into a faster system clock domain, and the edges of the bus clock and the enable are detected there. The system clock must run at least four times faster than the bus clock.

A frame opens on a rising edge of the enable. The data line is sampled on each bus clock rising edge while the enable is high, and the first bit on the wire is the least significant. Only the first eight bits count. When the enable falls after a full word, the word is committed. The low three bits go to the mode register and the upper five bits go to the gain register. A frame that falls short of eight bits is dropped.

The mode register is decoded into path enables and mix selects. The gain code is passed through unchanged. Code n means a gain of -34.5 + 1.5·n dB. A one-cycle update pulse tells downstream sequencing that the mode has changed.

Top module: `audio_ctl_regs`

## Requirements
- R1: After reset, mode_o is 0, gain_o is 27 (+6 dB), all six path outputs are low and update_o is low.
- R2: A frame of exactly 8 bits is committed with the first bit received as bit 0. Bits 2:0 become mode_o and bits 7:3 become gain_o.
- R3: If the enable falls after fewer than 8 bus clock rising edges, mode_o and gain_o keep their previous values.
- R4: Bus clock edges after the eighth in the same frame are ignored, so the committed word is the first 8 bits.
- R5: A rising edge of the enable restarts bit collection, so bits left over from an earlier short frame never count toward the next frame's 8.
- R6: The path outputs follow the mode as follows:
  - Mode 0: all paths off.
  - Mode 1: spk_en and spk_phone.
  - Mode 2: hs_en and hs_phone.
  - Mode 3: spk_en and spk_mix.
  - Mode 4: hs_en and hs_stereo.
  - Mode 5: spk_en, spk_mix and spk_phone.
  - Mode 6: hs_en, hs_stereo and hs_phone.
  - Mode 7: spk_en, spk_phone, hs_en, hs_stereo and hs_phone.
- R7: gain_o always equals the last committed gain code.
- R8: update_o pulses high for exactly one system cycle when a commit changes the mode. It stays low when a commit leaves the mode unchanged, and it stays low for a dropped frame.
- R9: A committed word appears on the outputs no later than 4 system clock cycles after the enable pin goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Serial data line |
| sclk_i | input | 1 | Serial bit clock |
| sen_i | input | 1 | Frame enable, active high |
| mode_o | output | 3 | Committed mode register |
| gain_o | output | 5 | Committed gain code |
| spk_en_o | output | 1 | Speaker amplifier enable |
| spk_phone_o | output | 1 | Speaker takes the phone input at +6 dB |
| spk_mix_o | output | 1 | Speaker takes the gained R+L mix |
| hs_en_o | output | 1 | Headset amplifiers enable |
| hs_phone_o | output | 1 | Headset takes the phone input at 0 dB |
| hs_stereo_o | output | 1 | Headset takes the gained R and L channels |
| update_o | output | 1 | One-cycle pulse on a mode change |

## Verification
A wrong bit counter shows up within one frame. Either a short frame gets committed, or a 9th bit shifts the word by one place and corrupts both fields. Both are visible on mode_o and gain_o a few cycles after the enable falls. A wrong shift direction or field split garbles every committed word. A decode error shows on the path outputs as soon as the affected mode is committed, and a wrong change detector shows as a missing or extra update_o pulse in the window after the commit.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
  localparam int FRAME_BITS = 8;
  localparam int MODE_W     = 3;
  localparam int GAIN_W     = 5;
  localparam int GAIN_RST   = 27;  // +6 dB
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic spk_en;
    logic spk_phone;
    logic spk_mix;
    logic hs_en;
    logic hs_phone;
    logic hs_stereo;
  } route_t;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar b = 0; b < N; b++) begin : g_line
    logic [STAGES-1:0] stg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '0;
      else         stg_q <= {stg_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = stg_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= q_o;
  end

  assign rise_o = q_o & ~prev_q;
  assign fall_o = ~q_o & prev_q;
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import audio_ctl_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  data_i,
  input  logic                  sclk_rise_i,
  input  logic                  en_i,
  input  logic                  en_rise_i,
  input  logic                  en_fall_i,
  output logic [FRAME_BITS-1:0] word_o,
  output logic                  commit_o
);
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] sr_q;
  logic                  full;

  assign full = (cnt_q == CNT_W'(FRAME_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (en_rise_i) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (sclk_rise_i && en_i && !full) begin
      sr_q  <= {data_i, sr_q[FRAME_BITS-1:1]};  // LSB first
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o   = sr_q;
  assign commit_o = en_fall_i && full;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_BITS)) else $error("count overflow"); // R4
  AST_SHIFT_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q) && cnt_q != '0) |-> $past(en_i)) else $error("shift outside frame"); // R2
endmodule

// File: rtl/route_decode.sv
module route_decode
  import audio_ctl_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output route_t            route_o
);
  always_comb begin
    route_o = '0;
    unique case (mode_i)
      3'd0: ;
      3'd1: begin route_o.spk_en = 1'b1; route_o.spk_phone = 1'b1; end
      3'd2: begin route_o.hs_en  = 1'b1; route_o.hs_phone  = 1'b1; end
      3'd3: begin route_o.spk_en = 1'b1; route_o.spk_mix   = 1'b1; end
      3'd4: begin route_o.hs_en  = 1'b1; route_o.hs_stereo = 1'b1; end
      3'd5: begin
        route_o.spk_en = 1'b1; route_o.spk_mix = 1'b1; route_o.spk_phone = 1'b1;
      end
      3'd6: begin
        route_o.hs_en = 1'b1; route_o.hs_stereo = 1'b1; route_o.hs_phone = 1'b1;
      end
      default: begin
        route_o.spk_en = 1'b1; route_o.spk_phone = 1'b1;
        route_o.hs_en  = 1'b1; route_o.hs_stereo = 1'b1; route_o.hs_phone = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/audio_ctl_regs.sv
module audio_ctl_regs
  import audio_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              sen_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              spk_en_o,
  output logic              spk_phone_o,
  output logic              spk_mix_o,
  output logic              hs_en_o,
  output logic              hs_phone_o,
  output logic              hs_stereo_o,
  output logic              update_o
);
  localparam int I_DAT = 0;
  localparam int I_CLK = 1;
  localparam int I_EN  = 2;

  logic [2:0]            lvl, rise, fall;
  logic [FRAME_BITS-1:0] word;
  logic                  commit;
  logic [MODE_W-1:0]     mode_q;
  logic [GAIN_W-1:0]     gain_q;
  logic                  upd_q;
  route_t                route;

  bus_sync #(.N(3), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sen_i, sclk_i, sdata_i}),
    .q_o    (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  frame_rx u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_i      (lvl[I_DAT]),
    .sclk_rise_i (rise[I_CLK]),
    .en_i        (lvl[I_EN]),
    .en_rise_i   (rise[I_EN]),
    .en_fall_i   (fall[I_EN]),
    .word_o      (word),
    .commit_o    (commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      gain_q <= GAIN_W'(GAIN_RST);
      upd_q  <= 1'b0;
    end else begin
      upd_q <= commit && (word[MODE_W-1:0] != mode_q);
      if (commit) begin
        mode_q <= word[MODE_W-1:0];
        gain_q <= word[MODE_W +: GAIN_W];
      end
    end
  end

  route_decode u_dec (
    .mode_i  (mode_q),
    .route_o (route)
  );

  assign mode_o      = mode_q;
  assign gain_o      = gain_q;
  assign update_o    = upd_q;
  assign spk_en_o    = route.spk_en;
  assign spk_phone_o = route.spk_phone;
  assign spk_mix_o   = route.spk_mix;
  assign hs_en_o     = route.hs_en;
  assign hs_phone_o  = route.hs_phone;
  assign hs_stereo_o = route.hs_stereo;

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> ($stable(mode_q) && $stable(gain_q))) else $error("reg changed"); // R3
  AST_UPD_MEANS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (mode_q != $past(mode_q))) else $error("spurious update"); // R8
  AST_UPD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o) else $error("long update"); // R8
  AST_MODE0_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == '0) |-> !(spk_en_o || hs_en_o || spk_phone_o || spk_mix_o ||
                         hs_phone_o || hs_stereo_o)) else $error("standby leak"); // R6
  AST_HS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_phone_o || hs_stereo_o) |-> hs_en_o) else $error("headset source w/o enable"); // R6
  AST_SPK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spk_phone_o || spk_mix_o) |-> spk_en_o) else $error("speaker source w/o enable"); // R6
endmodule

// File: tb/audio_ctl_regs_tb.sv
module audio_ctl_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, sen = 1'b0;
  logic [2:0] mode;
  logic [4:0] gain;
  logic spk_en, spk_phone, spk_mix, hs_en, hs_phone, hs_stereo, upd;

  int checks = 0, errors = 0, upd_cnt = 0;
  logic [2:0] exp_mode = 3'd0;
  logic [4:0] exp_gain = 5'd27;
  int exp_upd = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  audio_ctl_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk), .sen_i(sen),
    .mode_o(mode), .gain_o(gain), .spk_en_o(spk_en), .spk_phone_o(spk_phone),
    .spk_mix_o(spk_mix), .hs_en_o(hs_en), .hs_phone_o(hs_phone),
    .hs_stereo_o(hs_stereo), .update_o(upd)
  );

  always @(negedge clk) if (rst_n && upd) upd_cnt++;

  // {spk_en, spk_phone, spk_mix, hs_en, hs_phone, hs_stereo}
  function automatic logic [5:0] exp_route(input logic [2:0] m);
    case (m)
      3'd0: return 6'b000_000;
      3'd1: return 6'b110_000;
      3'd2: return 6'b000_110;
      3'd3: return 6'b101_000;
      3'd4: return 6'b000_101;
      3'd5: return 6'b111_000;
      3'd6: return 6'b000_111;
      default: return 6'b110_111;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    check({req, " mode"}, int'(mode), int'(exp_mode));
    check("R7 gain", int'(gain), int'(exp_gain));
    check("R6 route", int'({spk_en, spk_phone, spk_mix, hs_en, hs_phone, hs_stereo}),
          int'(exp_route(exp_mode)));
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int n, input logic [15:0] bits, input string req);
    upd_cnt = 0;
    sen = 1'b1;
    wait_cyc(4);
    for (int i = 0; i < n; i++) begin
      sdata = bits[i];
      wait_cyc(4);
      sclk = 1'b1;
      wait_cyc(4);
      sclk = 1'b0;
    end
    wait_cyc(4);
    sen = 1'b0;
    exp_upd = 0;
    if (n >= 8) begin
      exp_upd  = (bits[2:0] != exp_mode) ? 1 : 0;
      exp_mode = bits[2:0];
      exp_gain = bits[7:3];
    end
    wait_cyc(4);
    check_outs({req, " R9"});
    wait_cyc(4);
    check("R8 update pulses", upd_cnt, exp_upd);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4851));
    wait_cyc(3);
    check_outs("R1");
    check("R1 update", int'(upd), 0);
    rst_n = 1'b1;
    wait_cyc(3);
    check_outs("R1");
    // R2/R6: every mode with assorted gains
    for (int m = 0; m < 8; m++) send(8, 16'({5'(m * 3 + 7), 3'(m)}), "R2");
    send(8, {8'h0, 5'd31, 3'd5}, "R2");
    send(8, {8'h0, 5'd0, 3'd3}, "R2");
    send(8, {8'h0, 5'd23, 3'd3}, "R8");  // same mode, no pulse
    // R3: short frames
    send(7, 16'h00FE, "R3");
    send(0, 16'h0000, "R3");
    // R4: long frame, trailing bits must be discarded
    send(12, 16'hA5_6C, "R4");
    send(16, 16'hFFF1, "R4");
    // R5: 6 then 3 bits must not combine into a commit
    send(6, 16'h002A, "R5");
    send(3, 16'h0007, "R5");
    send(8, 16'h00B2, "R5");
    // random frames
    for (int k = 0; k < 60; k++) begin
      int nb;
      nb = int'($urandom_range(12, 4));
      send(nb, 16'($urandom), (nb >= 8) ? "R2" : "R3");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule